// File: doc/BRIEF.md
# Interrupt Request Register and Delivery Engine

This block holds one request bit per interrupt pin and decides when a pin's routing entry is sent to the interrupt target side. Sources report line activity as one-cycle events: an assert event says the line was driven high, a deassert event says it was driven low. A neighbouring register block supplies the routing entries as a flat vector and can ask for a pin to be serviced again, for example after an end-of-interrupt or after an entry was rewritten.

Pending service attempts are taken one at a time, lowest pin number first. An attempt is refused when the entry is masked, or when it is level-triggered and its remote-IRR bit is set. An accepted attempt is offered downstream through a valid/ready handshake. The handshake returns how many targets took the interrupt. Edge deliveries are recorded in a delivered-edge bitmap, and level deliveries that reach at least one target set remote-IRR. One designated pin keeps a count of unacknowledged targets, and new assertions on that pin are dropped while the count is nonzero.

Top module: `irq_request_service`

## Requirements
- R1: After reset, every request, delivered-edge and remote-IRR bit reads 0, the unacknowledged count is 0, and `dlv_valid` is low.
- R2: A deassert event clears the pin's request bit on the next clock and starts no delivery. It overrides an assert event for the same pin in the same cycle.
- R3: An assert event sets the request bit. On an edge-triggered pin it also clears the delivered-edge bit. It queues a service attempt only if the pin is level-triggered or its request bit was clear.
- R4: An attempt is dropped with no delivery when the entry's mask bit (bit 13) is 1, or when its trigger bit (bit 12, 1 = level) is 1 and the pin's remote-IRR bit is 1.
- R5: A delivery holds `dlv_valid` high and its fields steady until `dlv_ready`. The fields come from the entry: vector bits 7:0, delivery mode 10:8, destination mode 11, trigger 12, destination 21:14. `dlv_level` is always 1.
- R6: Completing an edge delivery sets the pin's delivered-edge bit. `irr_status` equals the request bits with the delivered-edge bits cleared.
- R7: Completing a level delivery with a nonzero accepted count sets remote-IRR, and an accepted count of 0 leaves it unchanged. `rirr_clr` clears it. A pin whose entry is edge-triggered has remote-IRR forced to 0.
- R8: On pin `DPIN`, an assert event is ignored (no request, no attempt) while the count is nonzero. A delivery started from a line event on that pin loads the count with the accepted count. `ack_dec` lowers the count by one, and the count never goes below 0.
- R9: When several attempts are pending, the lowest-numbered pin is taken first, one delivery at a time.
- R10: `svc_req` queues an attempt only when the pin's request bit is set; otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_set | input | NPINS | Per-pin assert event |
| line_clr | input | NPINS | Per-pin deassert event |
| svc_req | input | NPINS | Per-pin service request from register block |
| rirr_clr | input | NPINS | Per-pin remote-IRR clear |
| ent_cfg | input | NPINS*22 | Routing entries, pin i at bits [22i+21:22i] |
| ack_dec | input | 1 | One acknowledgement on the designated pin |
| dlv_ready | input | 1 | Target side accepts the delivery |
| dlv_accepted | input | CNT_W | Number of targets that took it, valid with ready |
| dlv_valid | output | 1 | Delivery offered |
| dlv_vector | output | 8 | Delivered vector |
| dlv_dest | output | 8 | Destination ID |
| dlv_dmode | output | 1 | Destination mode |
| dlv_trig | output | 1 | Trigger mode, 1 = level |
| dlv_mode | output | 3 | Delivery mode |
| dlv_level | output | 1 | Level, always 1 |
| irr_status | output | NPINS | Request bits minus delivered-edge bits |
| rirr_status | output | NPINS | Remote-IRR bits |
| pend_cnt | output | CNT_W | Unacknowledged count for the designated pin |

## Verification
The hardest case to reach is when several rules hit the same pin in one cycle. Examples are an edge assertion landing in the cycle that the previous delivery on that pin completes, a remote-IRR clear colliding with a level completion, or an entry flipping to edge while its level delivery is still in flight. Directed sequences cover the ordered cases: deduplication, refusal, suppression on the designated pin, and lowest-first order. After that, a long run of sparse random events, a stalling ready and occasional entry rewrites drives these collisions. A behavioural model in the bench is compared with the ports on every cycle.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
  localparam int VEC_W   = 8;
  localparam int DEST_W  = 8;
  localparam int MODE_W  = 3;
  localparam int ENTRY_W = DEST_W + 3 + MODE_W + VEC_W;

  // bit layout: dest[21:14] mask[13] trig_lvl[12] dmode[11] mode[10:8] vector[7:0]
  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig_lvl;
    logic              dmode;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vector;
  } rte_t;

  typedef enum logic { S_IDLE = 1'b0, S_SEND = 1'b1 } dlv_state_t;

  function automatic rte_t rte_unpack(input logic [ENTRY_W-1:0] raw);
    return rte_t'(raw);
  endfunction

  function automatic logic svc_refused(input rte_t e, input logic rirr);
    return e.mask | (e.trig_lvl & rirr);
  endfunction
endpackage

// File: rtl/irq_line_track.sv
module irq_line_track #(
  parameter int NPINS = 24,
  parameter int DPIN  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] line_set,
  input  logic [NPINS-1:0] line_clr,
  input  logic [NPINS-1:0] svc_req,
  input  logic [NPINS-1:0] trig_lvl,
  input  logic [NPINS-1:0] edge_done,
  input  logic             dpin_busy,
  output logic [NPINS-1:0] irr_q,
  output logic [NPINS-1:0] dlvd_q,
  output logic [NPINS-1:0] line_req,
  output logic [NPINS-1:0] new_req
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic supp, ev, irr_r, dlvd_r;
    assign supp        = (i == DPIN) && dpin_busy;
    assign ev          = line_set[i] & ~line_clr[i] & ~supp;
    assign line_req[i] = ev & (trig_lvl[i] | ~irr_r);
    assign new_req[i]  = line_req[i] | (svc_req[i] & irr_r);
    assign irr_q[i]    = irr_r;
    assign dlvd_q[i]   = dlvd_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irr_r  <= 1'b0;
        dlvd_r <= 1'b0;
      end else begin
        irr_r  <= (irr_r & ~line_clr[i]) | ev;
        dlvd_r <= (dlvd_r | edge_done[i]) & ~(ev & ~trig_lvl[i]);
      end
    end
  end
endmodule

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
  parameter int NPINS = 24,
  parameter int DPIN  = 8,
  parameter int PIN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] new_req,
  input  logic             line_req_dpin,
  input  logic             idle,
  output logic [NPINS-1:0] grant,
  output logic [PIN_W-1:0] grant_pin,
  output logic             grant_any,
  output logic             grant_line
);
  logic [NPINS-1:0] pend_q;
  logic             pl_q;
  logic             found;

  always_comb begin
    grant_pin = '0;
    found     = 1'b0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        grant_pin = PIN_W'(i);
        found     = 1'b1;
      end
    end
  end

  assign grant_any  = idle & found;
  assign grant      = grant_any ? (NPINS'(1) << grant_pin) : '0;
  assign grant_line = pl_q && (grant_pin == PIN_W'(DPIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      pl_q   <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~grant) | new_req;
      pl_q   <= (pl_q & ~grant[DPIN]) | line_req_dpin;
    end
  end
endmodule

// File: rtl/irq_dlv_fsm.sv
module irq_dlv_fsm
  import irq_req_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int PIN_W = 5,
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS*ENTRY_W-1:0] ent_cfg,
  input  logic                     grant_any,
  input  logic [PIN_W-1:0]         grant_pin,
  input  logic                     grant_line,
  input  logic                     dlv_ready,
  input  logic [CNT_W-1:0]         dlv_accepted,
  input  logic [NPINS-1:0]         rirr_clr,
  input  logic                     ack_dec,
  output logic                     idle,
  output rte_t                     cur_e,
  output logic                     dlv_valid,
  output logic [NPINS-1:0]         rirr_q,
  output logic [CNT_W-1:0]         cnt_q,
  output logic [NPINS-1:0]         edge_done,
  output logic                     cnt_load,
  output logic                     refuse_fire
);
  rte_t             ent_arr [NPINS];
  rte_t             gsel;
  dlv_state_t       state;
  logic [PIN_W-1:0] cur_pin;
  logic             cur_line;
  logic             launch, finish;
  logic [NPINS-1:0] cur_hot, rirr_set, ent_lvl;

  for (genvar i = 0; i < NPINS; i++) begin : g_ent
    assign ent_arr[i] = rte_unpack(ent_cfg[i*ENTRY_W +: ENTRY_W]);
    assign ent_lvl[i] = ent_arr[i].trig_lvl;
  end

  assign gsel        = ent_arr[grant_pin];
  assign refuse_fire = grant_any & svc_refused(gsel, rirr_q[grant_pin]);
  assign launch      = grant_any & ~refuse_fire;
  assign idle        = (state == S_IDLE);
  assign dlv_valid   = (state == S_SEND);
  assign finish      = dlv_valid & dlv_ready;
  assign cur_hot     = NPINS'(1) << cur_pin;
  assign edge_done   = (finish && !cur_e.trig_lvl) ? cur_hot : '0;
  assign rirr_set    = (finish && cur_e.trig_lvl && dlv_accepted != '0) ? cur_hot : '0;
  assign cnt_load    = finish & cur_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_e    <= '0;
      cur_pin  <= '0;
      cur_line <= 1'b0;
      rirr_q   <= '0;
      cnt_q    <= '0;
    end else begin
      if (launch) begin
        state    <= S_SEND;
        cur_e    <= gsel;
        cur_pin  <= grant_pin;
        cur_line <= grant_line;
      end else if (finish) begin
        state <= S_IDLE;
      end
      rirr_q <= rirr_set | (rirr_q & ~rirr_clr & ent_lvl);
      if (cnt_load)
        cnt_q <= dlv_accepted;
      else if (ack_dec && cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/irq_request_service.sv
module irq_request_service
  import irq_req_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int DPIN  = 8,
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         line_set,
  input  logic [NPINS-1:0]         line_clr,
  input  logic [NPINS-1:0]         svc_req,
  input  logic [NPINS-1:0]         rirr_clr,
  input  logic [NPINS*ENTRY_W-1:0] ent_cfg,
  input  logic                     ack_dec,
  input  logic                     dlv_ready,
  input  logic [CNT_W-1:0]         dlv_accepted,
  output logic                     dlv_valid,
  output logic [VEC_W-1:0]         dlv_vector,
  output logic [DEST_W-1:0]        dlv_dest,
  output logic                     dlv_dmode,
  output logic                     dlv_trig,
  output logic [MODE_W-1:0]        dlv_mode,
  output logic                     dlv_level,
  output logic [NPINS-1:0]         irr_status,
  output logic [NPINS-1:0]         rirr_status,
  output logic [CNT_W-1:0]         pend_cnt
);
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  logic [NPINS-1:0] trig_lvl, edge_done, irr_q, dlvd_q, line_req, new_req, grant_w;
  logic [PIN_W-1:0] grant_pin;
  logic             grant_any, grant_line, idle, cnt_load, refuse_fire;
  rte_t             cur_e;

  for (genvar i = 0; i < NPINS; i++) begin : g_trig
    assign trig_lvl[i] = ent_cfg[i*ENTRY_W + 12];
  end

  irq_line_track #(.NPINS(NPINS), .DPIN(DPIN)) u_line (
    .clk(clk), .rst_n(rst_n), .line_set(line_set), .line_clr(line_clr),
    .svc_req(svc_req), .trig_lvl(trig_lvl), .edge_done(edge_done),
    .dpin_busy(pend_cnt != '0), .irr_q(irr_q), .dlvd_q(dlvd_q),
    .line_req(line_req), .new_req(new_req)
  );

  irq_pend_arb #(.NPINS(NPINS), .DPIN(DPIN), .PIN_W(PIN_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .new_req(new_req), .line_req_dpin(line_req[DPIN]),
    .idle(idle), .grant(grant_w), .grant_pin(grant_pin), .grant_any(grant_any),
    .grant_line(grant_line)
  );

  irq_dlv_fsm #(.NPINS(NPINS), .PIN_W(PIN_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ent_cfg(ent_cfg), .grant_any(grant_any),
    .grant_pin(grant_pin), .grant_line(grant_line), .dlv_ready(dlv_ready),
    .dlv_accepted(dlv_accepted), .rirr_clr(rirr_clr), .ack_dec(ack_dec),
    .idle(idle), .cur_e(cur_e), .dlv_valid(dlv_valid), .rirr_q(rirr_status),
    .cnt_q(pend_cnt), .edge_done(edge_done), .cnt_load(cnt_load),
    .refuse_fire(refuse_fire)
  );

  assign dlv_vector = cur_e.vector;
  assign dlv_dest   = cur_e.dest;
  assign dlv_dmode  = cur_e.dmode;
  assign dlv_trig   = cur_e.trig_lvl;
  assign dlv_mode   = cur_e.mode;
  assign dlv_level  = 1'b1;
  assign irr_status = irr_q & ~dlvd_q;
endmodule

// File: rtl/irq_req_chk.sv
module irq_req_chk #(
  parameter int NPINS = 24,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dlv_valid,
  input logic             dlv_ready,
  input logic [7:0]       dlv_vector,
  input logic [7:0]       dlv_dest,
  input logic             dlv_level,
  input logic [NPINS-1:0] grant,
  input logic             refuse_fire,
  input logic             cnt_load,
  input logic [CNT_W-1:0] pend_cnt,
  input logic [NPINS-1:0] line_clr,
  input logic [NPINS-1:0] irr_status
);
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_vector) && $stable(dlv_dest));

  a_r5_level_one: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> dlv_level);

  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r4_refused_no_send: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_fire |=> !dlv_valid);

  a_r8_count_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_load |=> pend_cnt <= $past(pend_cnt));

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irr_status & $past(line_clr)) == '0);
endmodule

bind irq_request_service irq_req_chk #(.NPINS(NPINS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
  .dlv_vector(dlv_vector), .dlv_dest(dlv_dest), .dlv_level(dlv_level),
  .grant(grant_w), .refuse_fire(refuse_fire), .cnt_load(cnt_load),
  .pend_cnt(pend_cnt), .line_clr(line_clr), .irr_status(irr_status)
);

// File: tb/test_irq_request_service.sv
module test_irq_request_service;
  localparam int N  = 24;
  localparam int DP = 8;
  localparam int CW = 8;
  localparam int EW = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] line_set = '0, line_clr = '0, svc_req = '0, rirr_clr = '0;
  logic [EW-1:0] ent [N];
  logic [N*EW-1:0] ent_cfg;
  logic ack_dec = 1'b0, dlv_ready = 1'b1;
  logic [CW-1:0] dlv_accepted = 8'd1;
  logic dlv_valid, dlv_dmode, dlv_trig, dlv_level;
  logic [7:0] dlv_vector, dlv_dest;
  logic [2:0] dlv_mode;
  logic [N-1:0] irr_status, rirr_status;
  logic [CW-1:0] pend_cnt;

  int checks = 0, errors = 0, cycles = 0;
  bit running = 1'b0;

  always #4 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) ent_cfg[i*EW +: EW] = ent[i];

  irq_request_service i_irq_request_service (
    .clk(clk), .rst_n(rst_n), .line_set(line_set), .line_clr(line_clr),
    .svc_req(svc_req), .rirr_clr(rirr_clr), .ent_cfg(ent_cfg), .ack_dec(ack_dec),
    .dlv_ready(dlv_ready), .dlv_accepted(dlv_accepted), .dlv_valid(dlv_valid),
    .dlv_vector(dlv_vector), .dlv_dest(dlv_dest), .dlv_dmode(dlv_dmode),
    .dlv_trig(dlv_trig), .dlv_mode(dlv_mode), .dlv_level(dlv_level),
    .irr_status(irr_status), .rirr_status(rirr_status), .pend_cnt(pend_cnt)
  );

  function automatic logic [EW-1:0] mk(int vec, int mode, int dm, int lvl, int msk, int dest);
    return {dest[7:0], msk[0], lvl[0], dm[0], mode[2:0], vec[7:0]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // ---------------- reference model ----------------
  bit m_irr [N], m_dlvd [N], m_pend [N], m_rirr [N];
  bit m_pl, m_busy, m_cur_line;
  int m_cnt, m_cur;
  logic [EW-1:0] m_ent;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_irr[i] = 0; m_dlvd[i] = 0; m_pend[i] = 0; m_rirr[i] = 0;
    end
    m_pl = 0; m_busy = 0; m_cur_line = 0; m_cnt = 0; m_cur = 0; m_ent = '0;
  endtask

  task automatic model_step();
    bit ev [N], lreq [N], nreq [N];
    int sel = -1;
    bit fin = m_busy && dlv_ready;
    int acc = int'(dlv_accepted);
    bit cur_lvl = m_ent[12];
    bit old_pl = m_pl;
    for (int i = 0; i < N; i++) begin
      bit blocked = (i == DP) && (m_cnt > 0);
      ev[i]   = line_set[i] && !line_clr[i] && !blocked;
      lreq[i] = ev[i] && (ent[i][12] || !m_irr[i]);
      nreq[i] = lreq[i] || (svc_req[i] && m_irr[i]);
    end
    if (!m_busy)
      for (int i = 0; i < N; i++) if (m_pend[i] && sel < 0) sel = i;
    // per pin state
    for (int i = 0; i < N; i++) begin
      bit r;
      if (fin && !cur_lvl && i == m_cur) m_dlvd[i] = 1;
      if (ev[i] && !ent[i][12]) m_dlvd[i] = 0;
      if (line_clr[i]) m_irr[i] = 0;
      if (ev[i]) m_irr[i] = 1;
      r = m_rirr[i] && !rirr_clr[i] && ent[i][12];
      if (fin && cur_lvl && acc != 0 && i == m_cur) r = 1;
      m_rirr[i] = r;
      if (i == sel) m_pend[i] = 0;
      if (nreq[i]) m_pend[i] = 1;
    end
    if (fin && m_cur_line) m_cnt = acc;
    else if (ack_dec && m_cnt > 0) m_cnt--;
    if (sel == DP) m_pl = 0;
    if (lreq[DP]) m_pl = 1;
    if (fin) m_busy = 0;
    if (sel >= 0 && !(ent[sel][13] || (ent[sel][12] && m_rirr_old(sel)))) begin
      m_busy = 1; m_cur = sel; m_ent = ent[sel];
      m_cur_line = (sel == DP) && old_pl;
    end
  endtask

  // remote-IRR as seen before this step's update
  bit m_rirr_prev [N];
  function automatic bit m_rirr_old(int p);
    return m_rirr_prev[p];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      for (int i = 0; i < N; i++) m_rirr_prev[i] = m_rirr[i];
      model_step();
    end
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 200000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (running) begin
      logic [N-1:0] e_irr, e_rirr;
      for (int i = 0; i < N; i++) begin
        e_irr[i]  = m_irr[i] & ~m_dlvd[i];
        e_rirr[i] = m_rirr[i];
      end
      chk("R2 R3 R6 R8 R10 irr_status", 64'(irr_status), 64'(e_irr));
      chk("R7 rirr_status", 64'(rirr_status), 64'(e_rirr));
      chk("R8 pend_cnt", 64'(pend_cnt), 64'(m_cnt));
      chk("R4 R9 dlv_valid", 64'(dlv_valid), 64'(m_busy));
      if (m_busy) begin
        chk("R5 R9 payload",
            64'({dlv_dest, dlv_trig, dlv_dmode, dlv_mode, dlv_vector}),
            64'({m_ent[21:14], m_ent[12], m_ent[11], m_ent[10:8], m_ent[7:0]}));
        chk("R5 level", 64'(dlv_level), 64'd1);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_set(int p);
    line_set[p] = 1'b1; step(); line_set[p] = 1'b0;
  endtask

  task automatic pulse_clr(int p);
    line_clr[p] = 1'b1; step(); line_clr[p] = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) ent[i] = mk(i + 16, 0, 0, 0, 1, 0);
    step(3);
    // R1: reset state at the ports
    chk("R1 irr_status", 64'(irr_status), 64'd0);
    chk("R1 rirr_status", 64'(rirr_status), 64'd0);
    chk("R1 pend_cnt", 64'(pend_cnt), 64'd0);
    chk("R1 dlv_valid", 64'(dlv_valid), 64'd0);
    rst_n = 1'b1;
    running = 1'b1;
    ent[1] = mk(8'h11, 0, 0, 1, 1, 4);
    ent[3] = mk(8'h33, 1, 0, 0, 0, 2);
    ent[5] = mk(8'h55, 0, 1, 1, 0, 7);
    ent[DP] = mk(8'h88, 0, 0, 0, 0, 1);
    step(2);
    // R3/R6: edge delivery, then a duplicate assertion while the request is set
    pulse_set(3); step(6);
    pulse_set(3); step(6);
    // R2: deassert clears the request; clear beats set in the same cycle
    pulse_clr(3);
    line_set[3] = 1'b1; line_clr[3] = 1'b1; step(); line_set = '0; line_clr = '0; step(4);
    // R4: masked pin
    pulse_set(1); step(4);
    // R7/R4: level pin delivered, then refused while remote-IRR is set
    pulse_set(5); step(6);
    pulse_set(5); step(6);
    rirr_clr[5] = 1'b1; step(); rirr_clr = '0;
    // R10: service request honoured with the request set, ignored without
    svc_req[5] = 1'b1; svc_req[7] = 1'b1; step(); svc_req = '0; step(6);
    // R7: zero accepted leaves remote-IRR clear
    rirr_clr[5] = 1'b1; step(); rirr_clr = '0;
    dlv_accepted = 8'd0; svc_req[5] = 1'b1; step(); svc_req = '0; step(6);
    dlv_accepted = 8'd1;
    // R9: two pins at once, lowest first; R5: hold under a stalled ready
    pulse_clr(3);
    dlv_ready = 1'b0;
    line_set[3] = 1'b1; line_set[5] = 1'b1; step(); line_set = '0;
    step(5); dlv_ready = 1'b1; step(10);
    // R8: designated pin count load, suppression, decrement to zero
    dlv_accepted = 8'd2; pulse_set(DP); step(5);
    dlv_accepted = 8'd1;
    pulse_clr(DP); pulse_set(DP); step(4);
    for (int k = 0; k < 3; k++) begin ack_dec = 1'b1; step(); ack_dec = 1'b0; step(); end
    pulse_set(DP); step(6);
    // random phase
    for (int c = 0; c < 5000; c++) begin
      for (int i = 0; i < N; i++) begin
        line_set[i] = ($urandom % 18) == 0;
        line_clr[i] = ($urandom % 30) == 0;
        svc_req[i]  = ($urandom % 40) == 0;
        rirr_clr[i] = ($urandom % 25) == 0;
      end
      ack_dec      = ($urandom % 6) == 0;
      dlv_ready    = ($urandom % 3) != 0;
      dlv_accepted = CW'($urandom % 3);
      if (($urandom % 40) == 0) begin
        int p = $urandom % N;
        ent[p] = mk($urandom % 256, $urandom % 8, $urandom % 2, $urandom % 2,
                    ($urandom % 4) == 0, $urandom % 256);
      end
      step();
    end
    line_set = '0; line_clr = '0; svc_req = '0; rirr_clr = '0; ack_dec = 1'b0;
    dlv_ready = 1'b1;
    step(20);
    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule